// File: doc/BRIEF.md
# Set-Associative Cache Timing Controller

This block tracks the tag state of a configurable set-associative cache and decides, for every CPU load, store or modify request, which cache blocks hit, which miss and which force an eviction. It holds no data: it keeps one block number, a valid bit, a dirty bit and an LRU age per line. It charges each request a number of simulated cycles under a fixed cost model for cache and main-memory transfers. The geometry (set count, block size, ways), the write policy and both latencies are live configuration inputs. Their upper bounds are fixed by parameters.

A request is taken through a valid/ready handshake. The controller then works through one touched block per clock. A request that crosses block boundaries touches every block in its byte range. A modify request makes a second pass over the same blocks as a store. At the end it raises a one-cycle done pulse with the OR of the per-block outcomes and the cycle total. Running totals for the whole session sit on counter outputs.

Top module: `cache_ctl`

## Requirements
- R1: Once reset is released `req_ready` is high and the controller is idle. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` then stays low until `done` has been high for exactly one cycle, and it returns high on the cycle after `done`.
- R2: The block number is the address shifted right by `cfg_blk_lg`. The set is the block number modulo 2^`cfg_set_lg`. Only ways below `cfg_ways` are used. A miss fills the lowest-numbered invalid way and otherwise replaces the way in that set that has gone longest without being touched. Every hit and every fill counts as a touch.
- R3: Let Mb = `cfg_mem_lat` + 2^(`cfg_blk_lg`-3) - 1, which is the cost of one block transfer to or from memory, and let C = `cfg_cache_lat`. A load costs C per block that hits and Mb+C per block that misses.
- R4: When `cfg_wback` is 0 (write-through), a store costs C+Mb per block that hits and 2(C+Mb) per block that misses. Lines are never left dirty, and an eviction adds no cycles.
- R5: When `cfg_wback` is 1 (write-back), a store costs C per block that hits and Mb+2C per block that misses. The block is fetched first and then written. The stored line is left dirty.
- R6: In write-back mode, replacing a dirty line adds Mb to that block's cost. Replacing a clean line adds nothing.
- R7: `req_op` is coded 0 for load, 1 for store, 2 for modify, and 3 is handled as a load. A modify runs the load over all its blocks and then the store over the same blocks. It adds exactly one to `cnt_reads` and one to `cnt_writes`.
- R8: A request covers bytes `req_addr` to `req_addr`+`req_size`-1, and a size of 0 is taken as 1. Every block from the first to the last is checked in ascending order. Each block adds its own hit, miss and eviction to the counters, yet the request counts once as a read or a write.
- R9: On `done`, `res_hit`, `res_miss` and `res_evict` are each the OR of that outcome over every block step of the request. `res_cycles` is the sum of the step costs.
- R10: `cnt_hits`, `cnt_misses` and `cnt_evicts` count block steps. `cnt_reads` and `cnt_writes` count requests. `cnt_cycles` sums the request costs. All of them are 32-bit and saturate at all ones.
- R11: Reset invalidates every line and clears every counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_set_lg | input | 3 | log2 of the number of sets in use |
| cfg_blk_lg | input | 3 | log2 of the block size in bytes (3 or more) |
| cfg_ways | input | 3 | Ways in use, 1 to WAYS_MAX |
| cfg_wback | input | 1 | 1 selects write-back, 0 selects write-through |
| cfg_cache_lat | input | 16 | Cycles for one cache block access |
| cfg_mem_lat | input | 16 | Cycles for the first 8-byte memory unit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 0 load, 1 store, 2 modify, 3 load |
| req_addr | input | 64 | First byte address |
| req_size | input | 8 | Byte count (0 is taken as 1) |
| done | output | 1 | One-cycle pulse when results are valid |
| res_hit | output | 1 | Some block step hit |
| res_miss | output | 1 | Some block step missed |
| res_evict | output | 1 | Some block step replaced a valid line |
| res_cycles | output | 32 | Simulated cycles of the request |
| cnt_hits | output | 32 | Running hit count |
| cnt_misses | output | 32 | Running miss count |
| cnt_evicts | output | 32 | Running eviction count |
| cnt_reads | output | 32 | Running CPU read count |
| cnt_writes | output | 32 | Running CPU write count |
| cnt_cycles | output | 32 | Running cycle total |

## Verification
The assertions assume the configuration inputs are constant while a request is in flight and that they change only while reset is asserted. They also assume `cfg_blk_lg` is at least 3, `cfg_ways` lies between 1 and the way maximum, and no request's byte range wraps past the top of the address space. The bench follows all of this: it asserts reset before loading each new configuration, chooses only legal geometries, and keeps addresses in a low window with sizes below 32 bytes. The bench's own model tracks line recency with timestamps rather than ages, so the replacement order is checked by a second, independent method.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W = 64;
    localparam int CNT_W  = 32;
    localparam int SIZE_W = 8;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_MODIFY = 2'd2,
        OP_LOAD_B = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [ADDR_W-1:0] blk;
    } line_t;

    typedef struct packed {
        logic hit;
        logic miss;
        logic evict;
    } flags_t;

    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/cache_tags.sv
module cache_tags
    import cache_pkg::*;
#(
    parameter int SET_LG_MAX = 4,
    parameter int WAYS_MAX   = 4,
    localparam int SETS      = 1 << SET_LG_MAX,
    localparam int WIX       = (WAYS_MAX > 1) ? $clog2(WAYS_MAX) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [SET_LG_MAX-1:0]             set_idx,
    output line_t [WAYS_MAX-1:0]              rd_lines,
    output logic  [WAYS_MAX-1:0][WIX-1:0]     rd_age,
    input  logic                              wr_en,
    input  logic [WIX-1:0]                    wr_way,
    input  line_t                             wr_line
);
    line_t          lines [SETS][WAYS_MAX];
    logic [WIX-1:0] ages  [SETS][WAYS_MAX];

    always_comb begin
        for (int w = 0; w < WAYS_MAX; w++) begin
            rd_lines[w] = lines[set_idx][w];
            rd_age[w]   = ages[set_idx][w];
        end
    end

    // Touched way becomes youngest; valid ways younger than it age by one.
    // An invalid touched way counts as oldest, so every valid way ages.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS_MAX; w++) begin
                    lines[s][w] <= '0;
                    ages[s][w]  <= '0;
                end
            end
        end else if (wr_en) begin
            for (int w = 0; w < WAYS_MAX; w++) begin
                if (w == int'(wr_way)) begin
                    lines[set_idx][w] <= wr_line;
                    ages[set_idx][w]  <= '0;
                end else if (lines[set_idx][w].valid &&
                             (!lines[set_idx][wr_way].valid ||
                              ages[set_idx][w] < ages[set_idx][wr_way])) begin
                    ages[set_idx][w] <= ages[set_idx][w] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cache_victim.sv
module cache_victim
    import cache_pkg::*;
#(
    parameter int WAYS_MAX = 4,
    localparam int WIX     = (WAYS_MAX > 1) ? $clog2(WAYS_MAX) : 1,
    localparam int WCW     = $clog2(WAYS_MAX + 1)
) (
    input  line_t [WAYS_MAX-1:0]          lines,
    input  logic  [WAYS_MAX-1:0][WIX-1:0] ages,
    input  logic  [WCW-1:0]               cfg_ways,
    output logic  [WIX-1:0]               victim
);
    logic [WIX-1:0] oldest;

    always_comb begin
        oldest = WIX'(int'(cfg_ways) - 1);
        victim = '0;
        for (int w = WAYS_MAX - 1; w >= 0; w--) begin
            if (w < int'(cfg_ways) && ages[w] == oldest)
                victim = WIX'(w);
        end
        for (int w = WAYS_MAX - 1; w >= 0; w--) begin
            if (w < int'(cfg_ways) && !lines[w].valid)
                victim = WIX'(w);
        end
    end
endmodule

// File: rtl/cache_cost.sv
module cache_cost
    import cache_pkg::*;
#(
    parameter int LAT_W      = 16,
    parameter int BLK_LG_MAX = 6,
    localparam int BLW       = $clog2(BLK_LG_MAX + 1)
) (
    input  logic             is_store,
    input  logic             hit,
    input  logic             dirty_ev,
    input  logic             wback,
    input  logic [LAT_W-1:0] lat_cache,
    input  logic [LAT_W-1:0] lat_mem,
    input  logic [BLW-1:0]   blk_lg,
    output logic [CNT_W-1:0] cost
);
    logic [CNT_W-1:0] c_acc;
    logic [CNT_W-1:0] m_blk;

    always_comb begin
        c_acc = CNT_W'(lat_cache);
        m_blk = CNT_W'(lat_mem) + (CNT_W'(1) << (CNT_W'(blk_lg) - CNT_W'(3))) - CNT_W'(1);
        if (!is_store)
            cost = hit ? c_acc : m_blk + c_acc;
        else if (!wback)
            cost = hit ? c_acc + m_blk : (c_acc + m_blk) << 1;
        else
            cost = hit ? c_acc : m_blk + (c_acc << 1);
        if (dirty_ev)
            cost = cost + m_blk;
    end
endmodule

// File: rtl/cache_ctl.sv
module cache_ctl
    import cache_pkg::*;
#(
    parameter int SET_LG_MAX = 4,
    parameter int BLK_LG_MAX = 6,
    parameter int WAYS_MAX   = 4,
    parameter int LAT_W      = 16,
    localparam int SLW       = $clog2(SET_LG_MAX + 1),
    localparam int BLW       = $clog2(BLK_LG_MAX + 1),
    localparam int WCW       = $clog2(WAYS_MAX + 1),
    localparam int WIX       = (WAYS_MAX > 1) ? $clog2(WAYS_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLW-1:0]    cfg_set_lg,
    input  logic [BLW-1:0]    cfg_blk_lg,
    input  logic [WCW-1:0]    cfg_ways,
    input  logic              cfg_wback,
    input  logic [LAT_W-1:0]  cfg_cache_lat,
    input  logic [LAT_W-1:0]  cfg_mem_lat,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              done,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_evict,
    output logic [CNT_W-1:0]  res_cycles,
    output logic [CNT_W-1:0]  cnt_hits,
    output logic [CNT_W-1:0]  cnt_misses,
    output logic [CNT_W-1:0]  cnt_evicts,
    output logic [CNT_W-1:0]  cnt_reads,
    output logic [CNT_W-1:0]  cnt_writes,
    output logic [CNT_W-1:0]  cnt_cycles
);
    state_e             st;
    logic [ADDR_W-1:0]  cur_blk, first_blk, last_blk;
    logic               in_store, two_pass;
    flags_t             acc_f;
    logic [CNT_W-1:0]   acc_cyc;

    // request decode
    op_e                op;
    logic [SIZE_W-1:0]  size_eff;
    logic [ADDR_W-1:0]  end_addr;
    logic               take;

    assign op       = op_e'(req_op);
    assign size_eff = (req_size == '0) ? SIZE_W'(1) : req_size;
    assign end_addr = req_addr + ADDR_W'(size_eff) - ADDR_W'(1);
    assign take     = (st == ST_IDLE) && req_valid;

    // lookup of the current block
    logic [ADDR_W-1:0]            set_mask;
    logic [SET_LG_MAX-1:0]        set_idx;
    line_t [WAYS_MAX-1:0]         rd_lines;
    logic  [WAYS_MAX-1:0][WIX-1:0] rd_age;
    logic [WAYS_MAX-1:0]          hit_vec;
    logic [WIX-1:0]               hit_way, victim, use_way;
    logic                         hit, evict, dirty_ev;
    line_t                        new_line;
    logic [CNT_W-1:0]             step_cost;
    logic                         last_step;

    assign set_mask = (ADDR_W'(1) << cfg_set_lg) - ADDR_W'(1);
    assign set_idx  = SET_LG_MAX'(cur_blk & set_mask);

    always_comb begin
        hit_vec = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS_MAX; w++) begin
            if (w < int'(cfg_ways) && rd_lines[w].valid && rd_lines[w].blk == cur_blk)
                hit_vec[w] = 1'b1;
        end
        for (int w = WAYS_MAX - 1; w >= 0; w--) begin
            if (hit_vec[w])
                hit_way = WIX'(w);
        end
    end

    assign hit      = |hit_vec;
    assign evict    = !hit && rd_lines[victim].valid;
    assign dirty_ev = evict && rd_lines[victim].dirty && cfg_wback;
    assign use_way  = hit ? hit_way : victim;

    always_comb begin
        new_line.valid = 1'b1;
        new_line.blk   = cur_blk;
        new_line.dirty = ((hit && rd_lines[hit_way].dirty) || in_store) && cfg_wback;
    end

    assign last_step = (cur_blk == last_blk) && (!two_pass || in_store);

    cache_tags #(
        .SET_LG_MAX (SET_LG_MAX),
        .WAYS_MAX   (WAYS_MAX)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .set_idx  (set_idx),
        .rd_lines (rd_lines),
        .rd_age   (rd_age),
        .wr_en    (st == ST_WALK),
        .wr_way   (use_way),
        .wr_line  (new_line)
    );

    cache_victim #(
        .WAYS_MAX (WAYS_MAX)
    ) u_victim (
        .lines    (rd_lines),
        .ages     (rd_age),
        .cfg_ways (cfg_ways),
        .victim   (victim)
    );

    cache_cost #(
        .LAT_W      (LAT_W),
        .BLK_LG_MAX (BLK_LG_MAX)
    ) u_cost (
        .is_store  (in_store),
        .hit       (hit),
        .dirty_ev  (dirty_ev),
        .wback     (cfg_wback),
        .lat_cache (cfg_cache_lat),
        .lat_mem   (cfg_mem_lat),
        .blk_lg    (cfg_blk_lg),
        .cost      (step_cost)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cur_blk    <= '0;
            first_blk  <= '0;
            last_blk   <= '0;
            in_store   <= 1'b0;
            two_pass   <= 1'b0;
            acc_f      <= '0;
            acc_cyc    <= '0;
            cnt_hits   <= '0;
            cnt_misses <= '0;
            cnt_evicts <= '0;
            cnt_reads  <= '0;
            cnt_writes <= '0;
            cnt_cycles <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (take) begin
                        st        <= ST_WALK;
                        cur_blk   <= req_addr >> cfg_blk_lg;
                        first_blk <= req_addr >> cfg_blk_lg;
                        last_blk  <= end_addr >> cfg_blk_lg;
                        in_store  <= (op == OP_STORE);
                        two_pass  <= (op == OP_MODIFY);
                        acc_f     <= '0;
                        acc_cyc   <= '0;
                        if (op != OP_STORE)
                            cnt_reads <= sat_add(cnt_reads, CNT_W'(1));
                        if (op == OP_STORE || op == OP_MODIFY)
                            cnt_writes <= sat_add(cnt_writes, CNT_W'(1));
                    end
                end
                ST_WALK: begin
                    acc_f.hit   <= acc_f.hit | hit;
                    acc_f.miss  <= acc_f.miss | !hit;
                    acc_f.evict <= acc_f.evict | evict;
                    acc_cyc     <= sat_add(acc_cyc, step_cost);
                    cnt_cycles  <= sat_add(cnt_cycles, step_cost);
                    if (hit)
                        cnt_hits <= sat_add(cnt_hits, CNT_W'(1));
                    else
                        cnt_misses <= sat_add(cnt_misses, CNT_W'(1));
                    if (evict)
                        cnt_evicts <= sat_add(cnt_evicts, CNT_W'(1));
                    if (last_step) begin
                        st <= ST_DONE;
                    end else if (cur_blk == last_blk) begin
                        in_store <= 1'b1;
                        cur_blk  <= first_blk;
                    end else begin
                        cur_blk <= cur_blk + ADDR_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st == ST_IDLE);
    assign done       = (st == ST_DONE);
    assign res_hit    = acc_f.hit;
    assign res_miss   = acc_f.miss;
    assign res_evict  = acc_f.evict;
    assign res_cycles = acc_cyc;
endmodule

// File: rtl/cache_ctl_chk.sv
module cache_ctl_chk
    import cache_pkg::*;
#(
    parameter int LAT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic             done,
    input logic             res_hit,
    input logic             res_miss,
    input logic [CNT_W-1:0] res_cycles,
    input logic [LAT_W-1:0] cfg_cache_lat,
    input logic [CNT_W-1:0] cnt_hits,
    input logic [CNT_W-1:0] cnt_misses,
    input logic [CNT_W-1:0] cnt_evicts,
    input logic [CNT_W-1:0] cnt_reads,
    input logic [CNT_W-1:0] cnt_writes,
    input logic [CNT_W-1:0] cnt_cycles
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r1_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);
    a_r1_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        acc |=> !req_ready);
    a_r9_some_outcome: assert property (@(posedge clk) disable iff (rst)
        done |-> (res_hit || res_miss));
    a_r3_min_cost: assert property (@(posedge clk) disable iff (rst)
        done |-> (res_cycles >= CNT_W'(cfg_cache_lat)));
    a_r7_modify_counts: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 2'd2 && cnt_reads != '1 && cnt_writes != '1)
        |=> (cnt_reads == $past(cnt_reads) + 1 && cnt_writes == $past(cnt_writes) + 1));
    a_r8_req_counts_still: assert property (@(posedge clk) disable iff (rst)
        !acc |=> ($stable(cnt_reads) && $stable(cnt_writes)));
    a_r10_hits_mono: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cnt_hits >= $past(cnt_hits));
    a_r10_misses_mono: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cnt_misses >= $past(cnt_misses));
    a_r10_evicts_mono: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cnt_evicts >= $past(cnt_evicts));
    a_r10_cycles_mono: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cnt_cycles >= $past(cnt_cycles));
endmodule

bind cache_ctl cache_ctl_chk #(.LAT_W(LAT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .done          (done),
    .res_hit       (res_hit),
    .res_miss      (res_miss),
    .res_cycles    (res_cycles),
    .cfg_cache_lat (cfg_cache_lat),
    .cnt_hits      (cnt_hits),
    .cnt_misses    (cnt_misses),
    .cnt_evicts    (cnt_evicts),
    .cnt_reads     (cnt_reads),
    .cnt_writes    (cnt_writes),
    .cnt_cycles    (cnt_cycles)
);

// File: tb/cache_ctl_tb.sv
module cache_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 16;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_set_lg = 3'd2;
    logic [2:0]  cfg_blk_lg = 3'd4;
    logic [2:0]  cfg_ways   = 3'd1;
    logic        cfg_wback  = 1'b0;
    logic [15:0] cfg_cache_lat = 16'd13;
    logic [15:0] cfg_mem_lat   = 16'd230;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [63:0] req_addr = '0;
    logic [7:0]  req_size = 8'd1;
    logic        done, res_hit, res_miss, res_evict;
    logic [31:0] res_cycles, cnt_hits, cnt_misses, cnt_evicts, cnt_reads, cnt_writes, cnt_cycles;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_ctl u_dut (
        .clk(clk), .rst(rst), .cfg_set_lg(cfg_set_lg), .cfg_blk_lg(cfg_blk_lg),
        .cfg_ways(cfg_ways), .cfg_wback(cfg_wback), .cfg_cache_lat(cfg_cache_lat),
        .cfg_mem_lat(cfg_mem_lat), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_size(req_size), .done(done),
        .res_hit(res_hit), .res_miss(res_miss), .res_evict(res_evict),
        .res_cycles(res_cycles), .cnt_hits(cnt_hits), .cnt_misses(cnt_misses),
        .cnt_evicts(cnt_evicts), .cnt_reads(cnt_reads), .cnt_writes(cnt_writes),
        .cnt_cycles(cnt_cycles)
    );

    int checks = 0;
    int errors = 0;
    bit busy = 0;
    bit finished = 0;

    // behavioural model state: recency by timestamp
    bit              m_val [SETS][WAYS];
    bit              m_dty [SETS][WAYS];
    longint unsigned m_tag [SETS][WAYS];
    longint unsigned m_use [SETS][WAYS];
    longint unsigned stamp;
    longint unsigned e_hits, e_miss, e_evs, e_rd, e_wr, e_cyc;

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 0; m_dty[s][w] = 0; m_tag[s][w] = 0; m_use[s][w] = 0;
            end
        stamp = 1;
        e_hits = 0; e_miss = 0; e_evs = 0; e_rd = 0; e_wr = 0; e_cyc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic model_step(input longint unsigned blk, input bit st,
                              inout bit fh, inout bit fm, inout bit fe,
                              inout longint unsigned cyc);
        int s = int'(blk % (64'd1 << cfg_set_lg));
        int hw = -1;
        int vw = -1;
        longint unsigned c = cfg_cache_lat;
        longint unsigned mb = cfg_mem_lat + (64'd1 << (cfg_blk_lg - 3)) - 1;
        longint unsigned cost;
        for (int w = 0; w < int'(cfg_ways); w++)
            if (m_val[s][w] && m_tag[s][w] == blk) hw = w;
        if (hw >= 0) begin
            fh = 1; e_hits++;
            if (!st) cost = c;
            else if (!cfg_wback) cost = c + mb;
            else cost = c;
            if (st && cfg_wback) m_dty[s][hw] = 1;
            m_use[s][hw] = stamp;
        end else begin
            fm = 1; e_miss++;
            for (int w = int'(cfg_ways) - 1; w >= 0; w--)
                if (!m_val[s][w]) vw = w;
            if (vw < 0) begin
                vw = 0;
                for (int w = 1; w < int'(cfg_ways); w++)
                    if (m_use[s][w] < m_use[s][vw]) vw = w;
            end
            if (!st) cost = mb + c;
            else if (!cfg_wback) cost = 2 * (c + mb);
            else cost = mb + 2 * c;
            if (m_val[s][vw]) begin
                fe = 1; e_evs++;
                if (cfg_wback && m_dty[s][vw]) cost += mb;
            end
            m_val[s][vw] = 1; m_tag[s][vw] = blk;
            m_dty[s][vw] = st && cfg_wback;
            m_use[s][vw] = stamp;
        end
        stamp++;
        cyc += cost;
    endtask

    task automatic access(input int op, input longint unsigned addr, input int size,
                          input string req);
        bit fh = 0, fm = 0, fe = 0;
        longint unsigned cyc = 0;
        int sz = (size == 0) ? 1 : size;
        longint unsigned b0 = addr >> cfg_blk_lg;
        longint unsigned b1 = (addr + sz - 1) >> cfg_blk_lg;
        bit is_st = (op == 1);
        int n = 0;
        if (op != 1) e_rd++;
        if (op == 1 || op == 2) e_wr++;
        for (longint unsigned b = b0; b <= b1; b++) model_step(b, is_st, fh, fm, fe, cyc);
        if (op == 2)
            for (longint unsigned b = b0; b <= b1; b++) model_step(b, 1, fh, fm, fe, cyc);
        e_cyc += cyc;

        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = addr; req_size = 8'(size);
        @(posedge clk);
        busy = 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        busy = 0;
        chk(done == 1'b1, {req, " R1 done"}, done, 1);
        chk({res_hit, res_miss, res_evict} == {fh, fm, fe}, {req, " R9 flags"},
            {res_hit, res_miss, res_evict}, {fh, fm, fe});
        chk(res_cycles == 32'(cyc), {req, " R9 cycles"}, res_cycles, cyc);
        chk(cnt_hits == 32'(e_hits) && cnt_misses == 32'(e_miss) && cnt_evicts == 32'(e_evs),
            {req, " R10 step counters"}, {cnt_hits[15:0], cnt_misses[15:0], cnt_evicts[15:0]},
            {e_hits[15:0], e_miss[15:0], e_evs[15:0]});
        chk(cnt_reads == 32'(e_rd) && cnt_writes == 32'(e_wr), {req, " R7 request counters"},
            {cnt_reads[15:0], cnt_writes[15:0]}, {e_rd[15:0], e_wr[15:0]});
        chk(cnt_cycles == 32'(e_cyc), {req, " R10 cycle total"}, cnt_cycles, e_cyc);
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, {req, " R1 ready after done"}, {req_ready, done}, 2'b10);
    endtask

    // every clock: no readiness while a request is in flight
    always @(negedge clk) begin
        if (!rst && busy) begin
            checks++;
            if (req_ready) begin
                errors++;
                $display("FAIL R1 ready during request actual=%0d expected=0", req_ready);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint unsigned lcg;
        model_clear();
        // R11: reset state
        do_reset();
        chk(req_ready && !done, "R11 reset handshake", {req_ready, done}, 2'b10);
        chk(cnt_hits == 0 && cnt_misses == 0 && cnt_evicts == 0 && cnt_reads == 0 &&
            cnt_writes == 0 && cnt_cycles == 0, "R11 counters cleared", cnt_cycles, 0);

        // write-through, direct mapped, 4 sets of 16-byte blocks: Mb=231, C=13
        access(1, 64'h100, 1, "R4 wt store miss");       // 2*(13+231)=488
        chk(res_cycles == 488, "R4 wt store miss hand value", res_cycles, 488);
        access(0, 64'h108, 8, "R3 load hit");            // 13
        chk(res_cycles == 13, "R3 load hit hand value", res_cycles, 13);
        access(1, 64'h104, 4, "R4 wt store hit");        // 244
        chk(res_cycles == 244, "R4 wt store hit hand value", res_cycles, 244);
        access(2, 64'h140, 4, "R7 modify conflict");     // miss+evict 244, then hit 244
        chk(res_cycles == 488 && res_evict, "R4 wt eviction free", res_cycles, 488);
        access(0, 64'h104, 2, "R3 load miss");           // 244
        access(3, 64'h104, 1, "R7 op code 3 as load");
        access(0, 64'h1f8, 0, "R8 zero size");

        // write-back, 2 sets x 2 ways, 8-byte blocks: C=2, Mb=50
        cfg_set_lg = 3'd1; cfg_blk_lg = 3'd3; cfg_ways = 3'd2; cfg_wback = 1'b1;
        cfg_cache_lat = 16'd2; cfg_mem_lat = 16'd50;
        do_reset();
        access(1, 64'h00, 8, "R5 wb store miss");        // 54
        chk(res_cycles == 54, "R5 wb store miss hand value", res_cycles, 54);
        access(1, 64'h00, 4, "R5 wb store hit");         // 2
        chk(res_cycles == 2, "R5 wb store hit hand value", res_cycles, 2);
        access(0, 64'h10, 8, "R2 fill second way");
        access(0, 64'h20, 8, "R6 dirty eviction");      // victim blk0 dirty: 52+50
        chk(res_cycles == 102, "R6 dirty eviction hand value", res_cycles, 102);
        access(0, 64'h30, 8, "R6 clean eviction");      // victim blk2 clean: 52
        chk(res_cycles == 52, "R6 clean eviction hand value", res_cycles, 52);
        access(0, 64'h3c, 16, "R8 straddle three blocks");
        access(2, 64'h7c, 8, "R8 modify straddle");

        // LRU order: 1 set, 4 ways
        cfg_set_lg = 3'd0; cfg_ways = 3'd4; cfg_wback = 1'b0;
        do_reset();
        for (int i = 0; i < 4; i++) access(0, 64'(i * 8), 1, "R2 fill");
        access(0, 64'h00, 1, "R2 touch oldest");
        access(0, 64'h40, 1, "R2 replace least recent");
        access(0, 64'h08, 1, "R2 replaced block misses");
        access(0, 64'h00, 1, "R2 kept block hits");
        chk(res_hit && !res_miss, "R2 kept block hit flag", {res_hit, res_miss}, 2'b10);

        // random mixes, both policies
        lcg = 64'd12345;
        for (int pass = 0; pass < 2; pass++) begin
            cfg_set_lg = 3'd2; cfg_blk_lg = 3'(3 + pass); cfg_ways = 3'(3 + pass);
            cfg_wback = pass[0]; cfg_cache_lat = 16'd5; cfg_mem_lat = 16'd100;
            do_reset();
            for (int i = 0; i < 250; i++) begin
                lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
                access(int'(lcg[41:40]), {54'd0, lcg[49:40]}, int'(lcg[20:16]),
                       pass == 0 ? "R8 random wt" : "R5 random wb");
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule